// File: doc/BRIEF.md
# Dual-View Owned GPIO Controller

This block controls 32 general-purpose lines through two register views that sit side by side on one 32-bit memory-mapped bus. The open view can always be reached. The guarded view is reachable only while an external protection-enable input is high. An owner register lives in the guarded view and has one bit per line. It decides which of the two views may change and read that line's output value, direction, trigger level, flag and mask. A view that does not own a line cannot write that line's bits, and it reads them as zero.

Each line has a level-sensitive interrupt. The trigger level can be set to active-high or active-low. The interrupt has a sticky flag, cleared by writing a one, and a mask. The masked flags are combined into a single interrupt output. Pad inputs pass through a two-stage synchronizer before any register or flag uses them. Data on the bus is big-endian: byte lanes are reversed relative to line numbering.

A pad-enable register in the guarded view gates every output driver. It resets to all ones, so the direction bits alone decide driving until software narrows it.

Top module: `gpio_dual_view`

## Requirements
- R1: While reset is held, pad_out and pad_oe are all zero and irq is low. Owner, mask, output, direction, level and flag storage all clear to zero, and pad-enable clears to all ones.
- R2: The bus is big-endian. Line n of a register is carried on bus bit ((3 - n/8)*8 + n%8), so line 0 is on bus bit 24 and line 7 is on bus bit 31. This mapping applies to both writes and reads.
- R3: bus_addr is a word index (byte offset / 4). Open view: output 0, direction 1, input 2, level 3, flag 4, mask 5, input copy 6. Guarded view: pad-enable 7, output 8, direction 9, input 10, level 11, flag 12, mask 13, input copy 14, owner 15. Owner bit 1 gives a line to the open view, and owner bit 0 gives it to the guarded view.
- R4: A write through a view changes only the bits of lines that view owns. A read through a view returns 0 on the bits of lines it does not own.
- R5: While fw_en is low, writes to words 7 to 15 have no effect and reads of those words return 0. This includes the owner and pad-enable registers.
- R6: pad_out equals the output register. pad_oe is the direction bit (1 = drive) AND the pad-enable bit. Both update one clock after the write.
- R7: A change on pad_in becomes visible in the input and input-copy words after two clock edges and not after one. Writes to those words have no effect.
- R8: A flag bit sets on every clock edge at which the synchronized input equals that line's level bit (1 = active-high, 0 = active-low). A flag therefore appears three edges after the pad change.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. While the trigger condition still holds, the flag stays set despite a write-1.
- R10: irq is high exactly when some line has both its flag and mask bits set. It follows a mask write in the same cycle that the mask register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fw_en | input | 1 | Protection enable; opens the guarded view |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data, big-endian lanes |
| bus_rdata | output | 32 | Read data, big-endian lanes, 0 when idle |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined masked interrupt |

## Verification
A corrupted owner bit shows at the ports in the next cycle: a write meant for the wrong view moves pad_out, or a read of a correctly owned field returns a zero bit. A flag that sets or clears on the wrong condition shows on irq three edges after the pad moves, once the line is masked. Flags are also read back through both views, so a stuck or lost flag is exposed even while irq stays masked. Byte-lane or synchronizer-depth errors show as misplaced bits, or as input data one cycle early or late.

// File: rtl/gpio_dv_pkg.sv
package gpio_dv_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    F_OUT  = 3'd0,
    F_DIR  = 3'd1,
    F_IN   = 3'd2,
    F_LVL  = 3'd3,
    F_FLAG = 3'd4,
    F_MASK = 3'd5,
    F_COPY = 3'd6,
    F_NONE = 3'd7
  } field_e;

  typedef struct packed {
    logic   open_hit;
    logic   guard_hit;
    logic   pen_reg;
    logic   own_reg;
    field_e fld;
  } dec_t;

  // Reverse byte lanes between bus order and line order.
  function automatic logic [WORD_W-1:0] lane_swap(input logic [WORD_W-1:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // Word index to view/field; guarded words only hit while fw is high.
  function automatic dec_t decode_word(input logic [3:0] w, input logic fw);
    dec_t r;
    r = '{open_hit: 1'b0, guard_hit: 1'b0, pen_reg: 1'b0, own_reg: 1'b0, fld: F_NONE};
    if (w < 4'd7) begin
      r.open_hit = 1'b1;
      r.fld      = field_e'(w[2:0]);
    end else if (w == 4'd7) begin
      r.pen_reg  = fw;
    end else if (w == 4'd15) begin
      r.own_reg  = fw;
    end else begin
      r.guard_hit = fw;
      r.fld       = field_e'(w[2:0]);
    end
    return r;
  endfunction

  // Lines a view may touch for this access.
  function automatic logic [WORD_W-1:0] view_lines(input dec_t d, input logic [WORD_W-1:0] owner);
    if (d.open_hit)  return owner;
    if (d.guard_hit) return ~owner;
    return '0;
  endfunction
endpackage

// File: rtl/gpio_dv_sync.sv
module gpio_dv_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_dv_regs.sv
module gpio_dv_regs
  import gpio_dv_pkg::*;
#(
  parameter int unsigned   W        = WORD_W,
  parameter logic [W-1:0]  PEN_INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fw_en,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [3:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] sync_in,
  input  logic [W-1:0] flag_i,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] pen_q,
  output logic [W-1:0] owner_q,
  output logic [W-1:0] clr_o
);
  dec_t         dec_w;
  logic [W-1:0] lines_w;
  logic [W-1:0] wd_w;
  logic [W-1:0] wmask_w;
  logic [W-1:0] rd_w;
  logic         wr_w;

  assign dec_w   = decode_word(bus_addr, fw_en);
  assign lines_w = view_lines(dec_w, owner_q);
  assign wr_w    = bus_sel & bus_wr;
  assign wd_w    = lane_swap(bus_wdata);
  assign wmask_w = wr_w ? lines_w : '0;
  assign clr_o   = (dec_w.fld == F_FLAG) ? (wd_w & wmask_w) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      lvl_q   <= '0;
      mask_q  <= '0;
      pen_q   <= PEN_INIT;
      owner_q <= '0;
    end else begin
      if (dec_w.fld == F_OUT)  out_q  <= (out_q  & ~wmask_w) | (wd_w & wmask_w);
      if (dec_w.fld == F_DIR)  dir_q  <= (dir_q  & ~wmask_w) | (wd_w & wmask_w);
      if (dec_w.fld == F_LVL)  lvl_q  <= (lvl_q  & ~wmask_w) | (wd_w & wmask_w);
      if (dec_w.fld == F_MASK) mask_q <= (mask_q & ~wmask_w) | (wd_w & wmask_w);
      if (wr_w && dec_w.pen_reg) pen_q   <= wd_w;
      if (wr_w && dec_w.own_reg) owner_q <= wd_w;
    end
  end

  always_comb begin
    unique case (dec_w.fld)
      F_OUT:   rd_w = out_q;
      F_DIR:   rd_w = dir_q;
      F_IN:    rd_w = sync_in;
      F_LVL:   rd_w = lvl_q;
      F_FLAG:  rd_w = flag_i;
      F_MASK:  rd_w = mask_q;
      F_COPY:  rd_w = sync_in;
      default: rd_w = '0;
    endcase
    rd_w = rd_w & lines_w;
    if (dec_w.pen_reg) rd_w = pen_q;
    if (dec_w.own_reg) rd_w = owner_q;
  end

  assign bus_rdata = (bus_sel && !bus_wr) ? lane_swap(rd_w) : '0;
endmodule

// File: rtl/gpio_dv_irq.sv
module gpio_dv_irq #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_in,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] hit_o,
  output logic         irq_o
);
  // A line hits when its input sits at the selected level.
  assign hit_o = ~(sync_in ^ lvl_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_i) | hit_o;

  assign irq_o = |(flag_q & mask_i);
endmodule

// File: rtl/gpio_dual_view.sv
module gpio_dual_view
  import gpio_dv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] pad_in,
  output logic [WORD_W-1:0] pad_out,
  output logic [WORD_W-1:0] pad_oe,
  output logic              irq
);
  logic [WORD_W-1:0] sync_w;
  logic [WORD_W-1:0] out_w, dir_w, lvl_w, mask_w, pen_w, owner_w;
  logic [WORD_W-1:0] clr_w, flag_w, hit_w;

  gpio_dv_sync #(.W(WORD_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(pad_in), .q_o(sync_w)
  );

  gpio_dv_regs #(.W(WORD_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .fw_en(fw_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sync_in(sync_w), .flag_i(flag_w),
    .out_q(out_w), .dir_q(dir_w), .lvl_q(lvl_w), .mask_q(mask_w),
    .pen_q(pen_w), .owner_q(owner_w), .clr_o(clr_w)
  );

  gpio_dv_irq #(.W(WORD_W)) irq_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_w), .lvl_i(lvl_w),
    .mask_i(mask_w), .clr_i(clr_w), .flag_q(flag_w), .hit_o(hit_w),
    .irq_o(irq)
  );

  assign pad_out = out_w;
  assign pad_oe  = dir_w & pen_w;
endmodule

// File: rtl/gpio_dv_checker.sv
module gpio_dv_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        fw_en,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [31:0] pad_out,
  input logic        irq,
  input logic [31:0] owner_w,
  input logic [31:0] pen_w,
  input logic [31:0] mask_w,
  input logic [31:0] flag_w,
  input logic [31:0] hit_w,
  input logic [31:0] clr_w
);
  // R8: a hit in one cycle leaves its flag set in the next
  a_r8_flag_follows_level: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_w & $past(hit_w)) == $past(hit_w)));

  // R9: a flag only drops when a write-1 targeted it
  a_r9_flag_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((~flag_w) & $past(flag_w) & ~$past(clr_w)) == 32'd0));

  // R5: guarded-only registers hold while protection is closed
  a_r5_guard_closed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !fw_en |=> ($stable(owner_w) && $stable(pen_w)));

  // R10: no interrupt without a mask bit
  a_r10_no_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == 32'd0) |-> !irq);

  // R6: pad outputs move only after a bus write
  a_r6_out_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pad_out == $past(pad_out)) || $past(bus_sel && bus_wr)));
endmodule

bind gpio_dual_view gpio_dv_checker chk_i (
  .clk(clk), .rst_n(rst_n), .fw_en(fw_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .pad_out(pad_out), .irq(irq), .owner_w(owner_w), .pen_w(pen_w),
  .mask_w(mask_w), .flag_w(flag_w), .hit_w(hit_w), .clr_w(clr_w)
);

// File: tb/gpio_dual_view_tb_top.sv
module gpio_dual_view_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fw_en = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_dual_view dut_i (
    .clk(clk), .rst_n(rst_n), .fw_en(fw_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [31:0] to_bus(input logic [31:0] v);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*(3-b) +: 8] = v[8*b +: 8];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_raw(input logic [7:0] off, input logic [31:0] raw);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = off[5:2]; bus_wdata = raw;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] lines);
    wr_raw(off, to_bus(lines));
  endtask

  task automatic rd_raw(input logic [7:0] off, output logic [31:0] raw);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = off[5:2];
    #1 raw = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, output logic [31:0] lines);
    logic [31:0] raw;
    rd_raw(off, raw);
    lines = to_bus(raw);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    #1;
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    rd(8'h3C, v); check("R1 owner", v, 32'h0);
    rd(8'h34, v); check("R1 guarded mask", v, 32'h0);
    rd(8'h1C, v); check("R1 pad-enable", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_owner();
    logic [31:0] v;
    wr(8'h3C, 32'h0000_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    check("R3 open view out", pad_out, 32'h0000_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    check("R3 guarded view out", pad_out, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0000_00F0);
    check("R4 open write owned only", pad_out, 32'hFFFF_00F0);
    rd(8'h00, v); check("R4 open read masked", v, 32'h0000_00F0);
    rd(8'h20, v); check("R4 guarded read masked", v, 32'hFFFF_0000);
  endtask

  task automatic t_dir_enable();
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h24, 32'h0F0F_0000);
    check("R6 oe from both views", pad_oe, 32'h0F0F_FFFF);
    wr(8'h1C, 32'h0000_00FF);
    check("R6 oe gated by enable", pad_oe, 32'h0000_00FF);
    rd(8'h1C, v); check("R6 enable readback", v, 32'h0000_00FF);
    wr(8'h1C, 32'hFFFF_FFFF);
    check("R6 oe restored", pad_oe, 32'h0F0F_FFFF);
  endtask

  task automatic t_firewall();
    logic [31:0] v;
    fw_en = 1'b0;
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h20, 32'h0000_0000);
    check("R5 guarded write blocked", pad_out, 32'hFFFF_00F0);
    wr(8'h1C, 32'h0);
    check("R5 enable write blocked", pad_oe, 32'h0F0F_FFFF);
    rd(8'h20, v); check("R5 guarded read zero", v, 32'h0);
    rd(8'h3C, v); check("R5 owner read zero", v, 32'h0);
    fw_en = 1'b1;
    rd(8'h3C, v); check("R5 owner kept", v, 32'h0000_FFFF);
  endtask

  task automatic t_byte_order();
    logic [31:0] v;
    wr_raw(8'h00, 32'h8001_0000);
    check("R2 raw write lanes", pad_out, 32'hFFFF_0180);
    rd_raw(8'h20, v); check("R2 raw read lanes", v, 32'h0000_FFFF);
  endtask

  task automatic t_input();
    logic [31:0] v;
    pad_in = 32'hA5A5_1234;
    wait_cyc(1);
    rd(8'h08, v); check("R7 not after one edge", v, 32'h0);
    wait_cyc(1);
    rd(8'h08, v); check("R7 open input", v, 32'h0000_1234);
    rd(8'h28, v); check("R7 guarded input", v, 32'hA5A5_0000);
    rd(8'h18, v); check("R7 input copy", v, 32'h0000_1234);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R7 input write ignored", v, 32'h0000_1234);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    pad_in = 32'h0;
    wait_cyc(3);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R9 open flags cleared", v, 32'h0);
    rd(8'h30, v); check("R9 guarded flags cleared", v, 32'h0);
    pad_in = 32'h0000_0008;
    wait_cyc(2);
    rd(8'h10, v); check("R8 flag not yet", v, 32'h0);
    wait_cyc(1);
    rd(8'h10, v); check("R8 active-high flag", v, 32'h0000_0008);
    check("R10 masked off", {31'd0, irq}, 32'h0);
    wr(8'h14, 32'h0000_0008);
    check("R10 irq on mask", {31'd0, irq}, 32'h1);
    wr(8'h10, 32'h0);
    rd(8'h10, v); check("R9 write-0 keeps", v, 32'h0000_0008);
    wr(8'h10, 32'h0000_0008);
    rd(8'h10, v); check("R9 level holds flag", v, 32'h0000_0008);
    pad_in = 32'h0;
    wait_cyc(3);
    wr(8'h10, 32'h0000_0008);
    rd(8'h10, v); check("R9 write-1 clears", v, 32'h0);
    check("R10 irq drops", {31'd0, irq}, 32'h0);
    // active-low on guarded line 20
    wr(8'h2C, ~32'h0010_0000);
    wait_cyc(1);
    rd(8'h30, v); check("R8 active-low flag", v, 32'h0010_0000);
    pad_in = 32'h0010_0000;
    wait_cyc(3);
    wr(8'h10, 32'h0010_0000);
    rd(8'h30, v); check("R4 wrong-view clear ignored", v, 32'h0010_0000);
    wr(8'h30, 32'h0010_0000);
    rd(8'h30, v); check("R9 guarded clear", v, 32'h0);
    wr(8'h34, 32'h0010_0000);
    check("R10 no flag no irq", {31'd0, irq}, 32'h0);
    pad_in = 32'h0;
    wait_cyc(2);
    check("R10 irq not yet", {31'd0, irq}, 32'h0);
    wait_cyc(1);
    check("R10 active-low irq", {31'd0, irq}, 32'h1);
    fw_en = 1'b0;
    rd(8'h30, v); check("R5 flag hidden", v, 32'h0);
    fw_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(2);
    t_owner();
    t_dir_enable();
    t_firewall();
    t_byte_order();
    t_input();
    t_flags();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule